// File: doc/BRIEF.md
# Dual-Threshold Overrange Detector

This block watches the stream of signed conversion results from one converter channel, one sample per clock, and raises two warning flags. Each flag has its own 8-bit threshold. The block takes the magnitude of every sample and compares its top eight bits with each threshold. A flag goes high on the clock edge that captures a sample above its threshold.

After the last qualifying sample, a flag stays high for a programmable number of clocks. Short bursts of excessive input therefore remain visible to slow logic such as gain control or interrupt sampling. One 4-bit hold selector sets that time for both flags, as a power of two in clocks.

Each channel of a multi-channel converter uses its own instance. A common setup uses a lower threshold as an early warning and a higher one for clipping.

Top module: `ovr_detect_top`

## Requirements
- R1: While `rst` is high on a clock edge, both flags are low after that edge. Reset is synchronous and active high.
- R2: The magnitude of a sample is its absolute value, taken as two's complement. The most negative code (only the sign bit set) saturates to the largest positive magnitude, all ones in 11 bits, so its top eight bits read 255.
- R3: A sample exceeds a threshold only when bits [10:3] of its 11-bit magnitude are strictly greater than that 8-bit threshold. Equality does not exceed.
- R4: A flag is high after the first rising clock edge that captures an exceeding sample. The latency is one cycle.
- R5: After the last exceeding sample, a flag stays high for exactly 2^N consecutive cycles, where N is `hold_sel` at the time of that sample. It then drops if no further sample exceeds.
- R6: An exceeding sample that arrives while a flag is held restarts the hold at the full length 2^N. The flag does not drop in between.
- R7: The two flags are independent. Each responds only to its own threshold, and a sample may set one flag without the other.
- R8: With N = 0, each flag is simply the registered result of its comparison on the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 12 | Signed two's-complement sample, one per clock |
| thr_lo | input | 8 | Threshold for flag `ovr_lo`, compared with magnitude bits [10:3] |
| thr_hi | input | 8 | Threshold for flag `ovr_hi`, compared with magnitude bits [10:3] |
| hold_sel | input | 4 | Hold exponent N; a flag is held for 2^N cycles |
| ovr_lo | output | 1 | Registered overrange flag for `thr_lo` |
| ovr_hi | output | 1 | Registered overrange flag for `thr_hi` |

## Verification
Two functions can fall in the same cycle: a hold can be expiring on the very edge where a new exceeding sample arrives, and the hold exponent can change on that same edge. The bench places directed exceedances exactly 2^N cycles apart, so that a reload meets the last held cycle, and it also switches `hold_sel` in the middle of a hold. Random stimulus changes both thresholds and the exponent often. Every cycle, each flag is judged against a bench model that stores only the cycle at which the latest exceedance expires.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

  // Counter width able to hold 2^(2^sel_w - 1) - 1, the longest reload value.
  function automatic int hold_cnt_width(input int sel_w);
    return (1 << sel_w) - 1;
  endfunction

  // Width of the unsigned magnitude of a signed sample.
  function automatic int mag_width(input int sample_w);
    return sample_w - 1;
  endfunction

endpackage

// File: rtl/ovr_mag.sv
module ovr_mag #(
  parameter int SAMPLE_W = 12,
  parameter int CMP_W    = 8
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [CMP_W-1:0]    mag_top
);
  localparam int MAG_W = ovr_pkg::mag_width(SAMPLE_W);

  logic [SAMPLE_W-1:0] negated;
  logic [MAG_W-1:0]    mag;

  always_comb begin
    negated = ~sample + SAMPLE_W'(1);
    if (!sample[SAMPLE_W-1]) begin
      mag = sample[MAG_W-1:0];
    end else if (sample[MAG_W-1:0] == '0) begin
      // most negative code: saturate to full positive scale
      mag = '1;
    end else begin
      mag = negated[MAG_W-1:0];
    end
    mag_top = mag[MAG_W-1 -: CMP_W];
  end

endmodule

// File: rtl/ovr_stretch.sv
module ovr_stretch #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [SEL_W-1:0] hold_sel,
  output logic             flag
);
  localparam int CNT_W = ovr_pkg::hold_cnt_width(SEL_W);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] reload;

  // 2^N - 1 further cycles after the first high cycle
  always_comb reload = (CNT_W'(1) << hold_sel) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      remain <= '0;
    end else if (hit) begin
      flag   <= 1'b1;
      remain <= reload;
    end else if (remain != '0) begin
      flag   <= 1'b1;
      remain <= remain - CNT_W'(1);
    end else begin
      flag   <= 1'b0;
    end
  end

endmodule

// File: rtl/ovr_detect_top.sv
module ovr_detect_top #(
  parameter int SAMPLE_W = 12,
  parameter int CMP_W    = 8,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [CMP_W-1:0]    thr_lo,
  input  logic [CMP_W-1:0]    thr_hi,
  input  logic [SEL_W-1:0]    hold_sel,
  output logic                ovr_lo,
  output logic                ovr_hi
);
  localparam int NUM_THR = 2;

  logic [CMP_W-1:0] mag_top;
  logic [CMP_W-1:0] thr_vec [NUM_THR];
  logic [NUM_THR-1:0] exceed;
  logic [NUM_THR-1:0] flags;

  always_comb begin
    thr_vec[0] = thr_lo;
    thr_vec[1] = thr_hi;
  end

  ovr_mag #(.SAMPLE_W(SAMPLE_W), .CMP_W(CMP_W)) u_mag (
    .sample  (sample),
    .mag_top (mag_top)
  );

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    always_comb exceed[g] = (mag_top > thr_vec[g]);

    ovr_stretch #(.SEL_W(SEL_W)) u_stretch (
      .clk      (clk),
      .rst      (rst),
      .hit      (exceed[g]),
      .hold_sel (hold_sel),
      .flag     (flags[g])
    );
  end

  assign ovr_lo = flags[0];
  assign ovr_hi = flags[1];

endmodule

// File: rtl/ovr_detect_chk.sv
module ovr_detect_chk #(
  parameter int SAMPLE_W = 12,
  parameter int CMP_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [SAMPLE_W-1:0] sample,
  input logic [CMP_W-1:0]    mag_top,
  input logic [1:0]          exceed,
  input logic [1:0]          flags
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  p_neg_sat_r2: assert property (@(posedge clk) disable iff (rst)
    (sample == MOST_NEG) |-> (mag_top == '1));

  for (genvar g = 0; g < 2; g++) begin : g_flag
    p_reset_low_r1: assert property (@(posedge clk)
      rst |=> !flags[g]);

    p_set_next_r4: assert property (@(posedge clk) disable iff (rst)
      exceed[g] |=> flags[g]);

    p_rise_cause_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[g]) |-> $past(exceed[g]));

    p_fall_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[g]) |-> !$past(exceed[g]));
  end

endmodule

bind ovr_detect_top ovr_detect_chk #(.SAMPLE_W(SAMPLE_W), .CMP_W(CMP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sample  (sample),
  .mag_top (mag_top),
  .exceed  (exceed),
  .flags   (flags)
);

// File: tb/test_ovr_detect_top.sv
`timescale 1ns/1ps
module test_ovr_detect_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] sample = '0;
  logic [7:0]  thr_lo = '0;
  logic [7:0]  thr_hi = '0;
  logic [3:0]  hold_sel = '0;
  logic        ovr_lo, ovr_hi;

  int checks = 0;
  int fails  = 0;
  int it     = 0;
  int until_lo = -1000;
  int until_hi = -1000;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ovr_detect_top i_ovr_detect_top (
    .clk(clk), .rst(rst), .sample(sample), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .hold_sel(hold_sel), .ovr_lo(ovr_lo), .ovr_hi(ovr_hi)
  );

  function automatic int mag8(input logic [11:0] s);
    int v;
    v = int'($signed(s));
    if (v < 0) v = -v;
    if (v > 2047) v = 2047;
    return v >> 3;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", tag, what, it, act, exp);
    end
  endtask

  // checks outputs from the previous sample, then drives the next one
  task automatic step(input logic [11:0] s, input logic [7:0] a, input logic [7:0] b,
                      input logic [3:0] n, input string tag);
    @(negedge clk);
    check(ovr_lo, it <= until_lo, tag, "ovr_lo");
    check(ovr_hi, it <= until_hi, tag, "ovr_hi");
    sample = s; thr_lo = a; thr_hi = b; hold_sel = n;
    if (mag8(s) > int'(a)) until_lo = it + (1 << n);
    if (mag8(s) > int'(b)) until_hi = it + (1 << n);
    it++;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1: large input during reset must not raise a flag
    sample = 12'h7FF; thr_lo = 8'd0; thr_hi = 8'd0; hold_sel = 4'd3;
    repeat (3) @(negedge clk);
    check(ovr_lo, 1'b0, "R1", "ovr_lo in reset");
    check(ovr_hi, 1'b0, "R1", "ovr_hi in reset");
    sample = '0;
    rst = 1'b0;

    // R4 / R8: one-cycle latency, N=0 follows comparison
    step(12'd0, 8'd100, 8'd200, 4'd0, "R4");
    step(12'd900, 8'd100, 8'd200, 4'd0, "R4");
    step(12'd0, 8'd100, 8'd200, 4'd0, "R4");
    step(12'd0, 8'd100, 8'd200, 4'd0, "R8");

    // R3: equality does not exceed, one more step does
    step({8'd100, 3'b111} & 12'h7FF, 8'd100, 8'd100, 4'd0, "R3");
    step(12'd0, 8'd100, 8'd100, 4'd0, "R3");
    step(12'd808, 8'd100, 8'd100, 4'd0, "R3");
    step(-12'sd808, 8'd100, 8'd100, 4'd0, "R3");
    step(-12'sd807, 8'd100, 8'd100, 4'd0, "R3");
    step(12'd0, 8'd100, 8'd100, 4'd0, "R3");

    // R2: most negative code saturates to 255
    step(12'h800, 8'd254, 8'd255, 4'd0, "R2");
    step(12'd0, 8'd254, 8'd255, 4'd0, "R2");
    step(12'h801, 8'd254, 8'd255, 4'd0, "R2");
    step(12'd0, 8'd254, 8'd255, 4'd0, "R2");

    // R5: single event held 2^3 cycles
    step(12'd1500, 8'd50, 8'd250, 4'd3, "R5");
    for (int k = 0; k < 12; k++) step(12'd0, 8'd50, 8'd250, 4'd3, "R5");

    // R6: reloads spaced exactly at the hold length, then mid-hold N change
    step(12'd1500, 8'd50, 8'd250, 4'd2, "R6");
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 3; k++) step(12'd0, 8'd50, 8'd250, 4'd2, "R6");
      step(12'd1500, 8'd50, 8'd250, 4'd2, "R6");
    end
    step(12'd0, 8'd50, 8'd250, 4'd5, "R6");
    step(-12'sd1500, 8'd50, 8'd250, 4'd1, "R6");
    for (int k = 0; k < 8; k++) step(12'd0, 8'd50, 8'd250, 4'd1, "R6");

    // R7: sample between thresholds sets only the lower flag
    step(12'd1000, 8'd60, 8'd200, 4'd2, "R7");
    for (int k = 0; k < 6; k++) step(12'd0, 8'd60, 8'd200, 4'd2, "R7");
    step(12'd1000, 8'd200, 8'd60, 4'd0, "R7");
    for (int k = 0; k < 3; k++) step(12'd0, 8'd200, 8'd60, 4'd0, "R7");

    // random mix
    begin
      logic [7:0] a, b;
      logic [3:0] n;
      logic [11:0] s;
      a = 8'd80; b = 8'd160; n = 4'd2;
      for (int k = 0; k < 4000; k++) begin
        if (k % 64 == 0) begin
          a = 8'($urandom_range(0, 255));
          b = 8'($urandom_range(0, 255));
          n = 4'($urandom_range(0, 6));
        end
        if (k % 97 == 50) n = 4'($urandom_range(0, 6));
        if ($urandom_range(0, 7) == 0) s = 12'($urandom);
        else s = 12'($signed(12'($urandom_range(0, 255))) - 12'sd128);
        step(s, a, b, n, (n == 4'd0) ? "R8" : "R5");
      end
    end
    for (int k = 0; k < 80; k++) step(12'd0, 8'd255, 8'd255, 4'd0, "R5");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule